// File: doc/BRIEF.md
# SPI Shift Engine

This block is a four-wire SPI master for one frame at a time. A one-cycle `start` pulse comes with a transmit word and three mode bits. The engine then pulls the active-low select line low, runs the serial clock from a divided system clock, and shifts the word out on `mosi` while it collects a word from `miso`. When the frame is over it releases the select line. In that same clock it pulses `done` and presents the received word. The serial clock idles low or high. Data is sampled on the leading or the trailing clock edge. Either end of the word can go first.

The frame length (`FRAME_W`, 4 to 16 bits) and the half-period of the serial clock (`HALF_DIV` system clocks, at least 1) are parameters. The mode bits and the transmit word are captured when a start is accepted. A start request that arrives while a frame is in progress is dropped. All outputs come straight from registers clocked by `clk`.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, and whenever no frame is in progress, `ssel_n` is 1, `busy` and `done` are 0, and `sclk` equals `idle_high` as sampled one clock earlier.
- R2: `ssel_n` falls in the clock after an accepted start. The first `sclk` edge comes `HALF_DIV` clocks later. Consecutive edges are `HALF_DIV` clocks apart. Each frame has exactly 2*`FRAME_W` edges. `ssel_n` rises `HALF_DIV` clocks after the last edge.
- R3: With `phase_late`=0, the first data bit is on `mosi` from the clock in which `ssel_n` falls. `miso` is sampled on edges 1, 3, 5, … and `mosi` changes only on edges 2, 4, ….
- R4: With `phase_late`=1, `mosi` takes each new bit on edges 1, 3, 5, … and `miso` is sampled on edges 2, 4, 6, ….
- R5: With `lsb_first`=0, word bit `FRAME_W`-1 goes out first and bit 0 goes out last. With `lsb_first`=1, bit 0 goes out first.
- R6: The k-th bit sampled from `miso` is stored at the same word index as the k-th bit sent on `mosi`.
- R7: `done` is high for exactly one clock, and that clock is the one in which `ssel_n` rises. `rx_word` changes only at that point and holds its value until the next `done`.
- R8: A start pulse while `busy` is 1 is ignored. It neither changes the frame in progress nor begins another frame afterwards.
- R9: `idle_high`, `phase_late`, `lsb_first` and `tx_word` are captured when a start is accepted. Changes to them during a frame do not alter the bits sent or how received bits are placed.
- R10: `busy` is 1 from the clock after an accepted start up to the clock of `done`. It is 0 in that clock.
- R11: In the clock where `ssel_n` rises, `sclk` is already back at the idle level captured for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a frame |
| tx_word | input | FRAME_W | Word to transmit, captured at start |
| idle_high | input | 1 | 1: serial clock idles high; 0: idles low |
| phase_late | input | 1 | 0: sample on odd edges; 1: sample on even edges |
| lsb_first | input | 1 | 0: most significant bit first; 1: least significant bit first |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rx_word | output | FRAME_W | Word received in the last frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ssel_n | output | 1 | Active-low slave select |

## Verification
The bench shows a wrong edge counter or phase state within one frame at the ports. It would appear as a frame with the wrong number of `sclk` edges, an edge spacing other than `HALF_DIV`, or a select release at which `sclk` is not at its idle level. A corrupt bit-position counter or wrong index mapping shows up at the end of the first frame that uses the affected order, either in the bits collected from `mosi` or in `rx_word`. Mode or word state that leaks through from the live inputs is exposed by changing every configuration input right after each accepted start. Logic that wrongly accepts a start while busy shows up as an extra select cycle after `done`.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL
    } eng_state_e;

    typedef struct packed {
        logic idle_high;
        logic phase_late;
        logic lsb_first;
    } eng_cfg_t;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: the counter never runs past the half-period limit
    a_r2_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/spi_bit_index.sv
module spi_bit_index #(
    parameter int FRAME_W = 8,
    parameter int PW      = 4
) (
    input  logic          lsb_first,
    input  logic [PW-1:0] pos,
    output logic [PW-1:0] idx
);
    localparam logic [PW-1:0] TOP_IDX = PW'(FRAME_W - 1);

    always_comb begin
        if (lsb_first) idx = pos;
        else           idx = TOP_IDX - pos;
    end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int FRAME_W  = 8,
    parameter int HALF_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               idle_high,
    input  logic               phase_late,
    input  logic               lsb_first,
    input  logic               miso,
    output logic               busy,
    output logic               done,
    output logic [FRAME_W-1:0] rx_word,
    output logic               sclk,
    output logic               mosi,
    output logic               ssel_n
);
    localparam int PW = $clog2(FRAME_W + 1);
    localparam int EW = $clog2(2 * FRAME_W + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * FRAME_W - 1);
    localparam logic [PW-1:0] NBITS     = PW'(FRAME_W);

    typedef struct packed {
        eng_state_e         st;
        eng_cfg_t           cfg;
        logic [FRAME_W-1:0] tx;
        logic [FRAME_W-1:0] rx_sh;
        logic [FRAME_W-1:0] rx_out;
        logic [PW-1:0]      txpos;
        logic [PW-1:0]      rxpos;
        logic [EW-1:0]      ecnt;
        logic               sclk;
        logic               mosi;
        logic               ssel_n;
        logic               done;
    } eng_regs_t;

    eng_regs_t r_d, r_q;
    logic      run, tick;
    logic [PW-1:0] tx_idx, rx_idx;

    assign run = (r_q.st != ST_IDLE);

    spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    spi_bit_index #(.FRAME_W(FRAME_W), .PW(PW)) u_tx_idx (
        .lsb_first(r_q.cfg.lsb_first),
        .pos      (r_q.txpos),
        .idx      (tx_idx)
    );

    spi_bit_index #(.FRAME_W(FRAME_W), .PW(PW)) u_rx_idx (
        .lsb_first(r_q.cfg.lsb_first),
        .pos      (r_q.rxpos),
        .idx      (rx_idx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sclk = idle_high;
                if (start) begin
                    r_d.st     = ST_LEAD;
                    r_d.cfg    = '{idle_high: idle_high, phase_late: phase_late,
                                   lsb_first: lsb_first};
                    r_d.tx     = tx_word;
                    r_d.ssel_n = 1'b0;
                    r_d.rxpos  = '0;
                    r_d.ecnt   = '0;
                    r_d.rx_sh  = '0;
                    if (phase_late) begin
                        r_d.mosi  = 1'b0;
                        r_d.txpos = '0;
                    end else begin
                        r_d.mosi  = lsb_first ? tx_word[0] : tx_word[FRAME_W-1];
                        r_d.txpos = PW'(1);
                    end
                end
            end
            ST_LEAD, ST_XFER: begin
                if (tick) begin
                    r_d.sclk = ~r_q.sclk;
                    r_d.ecnt = r_q.ecnt + EW'(1);
                    // even count before the edge means an odd edge number
                    if (r_q.ecnt[0] == r_q.cfg.phase_late) begin
                        r_d.rx_sh[rx_idx] = miso;
                        r_d.rxpos         = r_q.rxpos + PW'(1);
                    end else if (r_q.txpos < NBITS) begin
                        r_d.mosi  = r_q.tx[tx_idx];
                        r_d.txpos = r_q.txpos + PW'(1);
                    end
                    r_d.st = (r_q.ecnt == LAST_EDGE) ? ST_TRAIL : ST_XFER;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    r_d.st     = ST_IDLE;
                    r_d.ssel_n = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.rx_out = r_q.rx_sh;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.ssel_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy    = run;
    assign done    = r_q.done;
    assign rx_word = r_q.rx_out;
    assign sclk    = r_q.sclk;
    assign mosi    = r_q.mosi;
    assign ssel_n  = r_q.ssel_n;

    // R1: idle serial clock follows the idle-level input one clock later
    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ssel_n && $past(r_q.ssel_n) && $past(rst_n)) |-> (r_q.sclk == $past(idle_high)));

    // R2: the trailing phase is only reached after every edge and every sample
    a_r2_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TRAIL) |-> (r_q.ecnt == EW'(2 * FRAME_W) && r_q.rxpos == NBITS));

    // R7: done lasts a single clock
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R7: select release and done coincide
    a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ssel_n) |-> r_q.done);

    // R8: a start during a frame leaves the captured setup untouched
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start) |=> ($stable(r_q.cfg) && $stable(r_q.tx)));

    // R11: clock is at its captured idle level when select is released
    a_r11_idle_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ssel_n) |-> (r_q.sclk == r_q.cfg.idle_high));

endmodule

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
    localparam int N = 8;
    localparam int H = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] tx_word = '0;
    logic         idle_high = 1'b0, phase_late = 1'b0, lsb_first = 1'b0;
    logic         miso = 1'b0;
    logic         busy, done, sclk, mosi, ssel_n;
    logic [N-1:0] rx_word;

    always #4 clk = ~clk;

    spi_xfer_engine #(.FRAME_W(N), .HALF_DIV(H)) i_spi_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .idle_high(idle_high), .phase_late(phase_late), .lsb_first(lsb_first),
        .miso(miso), .busy(busy), .done(done), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .ssel_n(ssel_n)
    );

    typedef struct {
        logic [N-1:0] tx;
        logic [N-1:0] sw;
        logic pol, pha, lsb;
    } item_t;

    item_t sbq[$];
    int vectors = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bidx(int k, logic lsb);
        return lsb ? k : N - 1 - k;
    endfunction

    // monitor and slave model
    int cyc = 0, last_evt = 0, edges = 0, ns = 0, nd = 0;
    bit in_frame = 0;
    logic prev_sclk = 1'b0, prev_ssel = 1'b1, prev_done = 1'b0;
    logic [N-1:0] slave_rx = '0;
    item_t cur;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            miso = 1'b0;
            in_frame = 0;
        end else begin
            bit rel;
            rel = in_frame && !prev_ssel && ssel_n;
            if (prev_done && done) chk(0, "R7 done longer than one clock", 1, 0);
            if (done && !rel) chk(0, "R7 done without select release", 1, 0);
            if (prev_ssel && !ssel_n) begin
                if (sbq.size() == 0) begin
                    chk(0, "R8 frame started with no accepted request", 1, 0);
                end else begin
                    cur = sbq[0];
                    in_frame = 1; edges = 0; last_evt = cyc;
                    slave_rx = '0; ns = 0; nd = 0;
                    if (!cur.pha) begin
                        miso = cur.sw[bidx(0, cur.lsb)];
                        nd = 1;
                    end
                end
            end else if (rel) begin
                chk(edges == 2 * N, "R2 edge count", edges, 2 * N);
                chk(cyc - last_evt == H, "R2 trailing half period", cyc - last_evt, H);
                chk(sclk == cur.pol, "R11 clock idle at release", sclk, cur.pol);
                chk(done == 1'b1, "R7 done with release", done, 1);
                chk(busy == 1'b0, "R10 busy low at done", busy, 0);
                chk(rx_word == cur.sw, "R6 R9 received word", rx_word, cur.sw);
                chk(slave_rx == cur.tx, cur.pha ? "R4 R5 R9 bits on mosi" : "R3 R5 R9 bits on mosi",
                    slave_rx, cur.tx);
                void'(sbq.pop_front());
                in_frame = 0;
            end else if (in_frame && sclk != prev_sclk) begin
                edges++;
                chk(cyc - last_evt == H, "R2 half period", cyc - last_evt, H);
                last_evt = cyc;
                if ((edges % 2 == 1) != cur.pha) begin
                    if (ns < N) slave_rx[bidx(ns, cur.lsb)] = mosi;
                    ns++;
                end else if (nd < N) begin
                    miso = cur.sw[bidx(nd, cur.lsb)];
                    nd++;
                end
            end
        end
        prev_sclk = sclk;
        prev_ssel = ssel_n;
        prev_done = done;
    end

    // driver: queues the expected frame and runs it
    task automatic xfer(input logic [N-1:0] tx, input logic [N-1:0] sw,
                        input logic pol, input logic pha, input logic lsb, input bit poke);
        item_t it;
        logic [N-1:0] held;
        it.tx = tx; it.sw = sw; it.pol = pol; it.pha = pha; it.lsb = lsb;
        while (busy) @(negedge clk);
        sbq.push_back(it);
        tx_word = tx; idle_high = pol; phase_late = pha; lsb_first = lsb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !ssel_n, "R10 R2 busy and select after start", {busy, ssel_n}, 2'b10);
        // R9: disturb every captured input during the frame
        tx_word = ~tx; idle_high = ~pol; phase_late = ~pha; lsb_first = ~lsb;
        if (poke) begin
            repeat (5) @(negedge clk);
            tx_word = 8'h00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        held = rx_word;
        repeat (4) @(negedge clk);
        chk(rx_word == held, "R7 received word held", rx_word, held);
        chk(ssel_n && !done && !busy, "R8 no further frame", {ssel_n, done, busy}, 3'b100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ssel_n && !busy && !done, "R1 reset state", {ssel_n, busy, done}, 3'b100);
        rst_n = 1'b1;
        idle_high = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R1 idle level high", sclk, 1);
        idle_high = 1'b0;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R1 idle level low", sclk, 0);
        chk(ssel_n && !busy && !done, "R1 idle outputs", {ssel_n, busy, done}, 3'b100);

        for (int m = 0; m < 8; m++) begin
            xfer(8'hA5 ^ 8'(m * 19), 8'h3C + 8'(m * 7), m[0], m[1], m[2], 1'b0);
        end
        xfer(8'h01, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0);
        xfer(8'h01, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0);
        xfer(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
        xfer(8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0);
        // R8: start pulsed while busy
        xfer(8'h96, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
        xfer(8'h3E, 8'hC1, 1'b1, 1'b1, 1'b0, 1'b1);
        chk(sbq.size() == 0, "R8 scoreboard drained", sbq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            vectors++;
            errors++;
            $display("FAIL watchdog R2: actual %0d cycles expected fewer", wd);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule